// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block collects four events from a line-interface receiver into a sticky status register and raises one interrupt line. The events are: a change in the activation indicators (two received-info flags plus a 3-bit activation state), a rising edge of the frame-sync error level, a completed Q-channel nibble, and readiness for the next set of S-channel nibbles. A host reads the status register over a byte-wide register bus. The read returns the pending bits and clears them.

A separate read/write enable register masks each source. The interrupt output is a registered OR of the pending bits that are enabled. The level inputs are registered and compared with their previous sample to find changes and edges. The two pulse inputs set their bits directly.

Top module: `irq_status_unit`

## Requirements
- R1: The status register is at address 0x16 and reads bits 3..0 as {state change, frame-sync error, Q nibble, S ready}. The enable register is at 0x17 and reads its four enable bits in the same positions. Bits 7..4 of both registers, and every other address, read as 0. Read data follows the address combinationally.
- R2: After reset the status register, the enable register and the interrupt output are all 0.
- R3: A cycle with the read strobe high and the address at 0x16 returns the status held before the read. At that clock edge it clears all status bits.
- R4: An event that lands in the same cycle as a status read is still set after the clear.
- R5: Status bit 3 is set at the second clock edge after any of the two info flags or the 3-bit state changes value.
- R6: Status bit 2 is set at the second clock edge after the frame-sync error level goes from 0 to 1. While the level stays high, a read clears the bit and the bit does not set again. It sets again only after the level falls and rises again.
- R7: A high cycle on the Q-nibble pulse sets status bit 1 at the next edge. A high cycle on the S-ready pulse sets status bit 0 at the next edge.
- R8: A write to 0x17 loads write-data bits 3..0 into the enable register. A 1 enables the matching status bit.
- R9: The interrupt output is high in the cycle after the status register and the enable register share a set bit. It is low in the cycle after they share none.
- R10: Writes to 0x16 have no effect on the status register.
- R11: Levels present on the state and error inputs when reset is released set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe; a read of 0x16 clears the status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| act_state | input | 3 | Activation state field |
| info_hi | input | 1 | First received-info flag |
| info_lo | input | 1 | Second received-info flag |
| fsync_err | input | 1 | Raw frame-sync error level |
| q_nib_done | input | 1 | Pulse: Q-channel nibble received |
| s_nib_ready | input | 1 | Pulse: S-channel nibbles sent, next set may be written |
| irq | output | 1 | Registered, active-high interrupt |

## Verification
Two cases are hard to reach from the ports. One is a frame-sync error level that stays high across a clearing read: no new set may follow until the level falls and rises again. The other is an event that arrives in exactly the cycle of a status read. Directed sequences build both cases by holding the error level over several reads, and by issuing pulses and level changes aligned with the read strobe at the two-edge latency of the sampled inputs. Seeded random traffic then mixes reads, enable writes, writes to the status address, pulses and level changes. A cycle model in the bench, built from the requirements, predicts the read data and the interrupt.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int ADDR_W = 8,
  parameter int STATE_W = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h16,
  parameter logic [ADDR_W-1:0] EN_ADDR = 'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [STATE_W-1:0] act_state,
  input  logic              info_hi,
  input  logic              info_lo,
  input  logic              fsync_err,
  input  logic              q_nib_done,
  input  logic              s_nib_ready,
  output logic              irq
);
  localparam int NSRC = 4;
  localparam int WATCH_W = STATE_W + 2;

  logic [WATCH_W-1:0] watch_cur, watch_prv;
  logic               fs_cur, fs_prv;
  logic               cur_vld, prv_vld;
  logic [NSRC-1:0]    status, en, events;
  logic               irq_q;

  wire stat_sel = (bus_addr == STAT_ADDR);
  wire en_sel   = (bus_addr == EN_ADDR);
  wire clr      = bus_rd && stat_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      watch_cur <= '0;
      watch_prv <= '0;
      fs_cur    <= 1'b0;
      fs_prv    <= 1'b0;
      cur_vld   <= 1'b0;
      prv_vld   <= 1'b0;
    end else begin
      watch_cur <= {info_hi, info_lo, act_state};
      fs_cur    <= fsync_err;
      watch_prv <= watch_cur;
      fs_prv    <= fs_cur;
      cur_vld   <= 1'b1;
      prv_vld   <= cur_vld;
    end
  end

  assign events[3] = prv_vld && (watch_cur != watch_prv);
  assign events[2] = prv_vld && fs_cur && !fs_prv;
  assign events[1] = q_nib_done;
  assign events[0] = s_nib_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      en     <= '0;
      irq_q  <= 1'b0;
    end else begin
      status <= (clr ? '0 : status) | events;
      if (bus_wr && en_sel) en <= bus_wdata[NSRC-1:0];
      irq_q <= |(status & en);
    end
  end

  assign irq = irq_q;
  assign bus_rdata = stat_sel ? {{(8-NSRC){1'b0}}, status} :
                     en_sel   ? {{(8-NSRC){1'b0}}, en} : 8'h00;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h16,
  parameter logic [ADDR_W-1:0] EN_ADDR = 'h17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              q_nib_done,
  input logic              s_nib_ready,
  input logic              irq,
  input logic [3:0]        status,
  input logic [3:0]        en
);
  wire rd_stat = bus_rd && (bus_addr == STAT_ADDR);
  wire wr_en   = bus_wr && (bus_addr == EN_ADDR);

  a_r7_q_sets: assert property (@(posedge clk) disable iff (!rst_n)
    q_nib_done |=> status[1]);
  a_r7_s_sets: assert property (@(posedge clk) disable iff (!rst_n)
    s_nib_ready |=> status[0]);
  a_r3_read_clears_q: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !q_nib_done) |=> !status[1]);
  a_r3_read_clears_s: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !s_nib_ready) |=> !status[0]);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:4] == 4'h0);
  a_r8_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en == $past(bus_wdata[3:0]));
  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & en)) |=> irq);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & en)) |=> !irq);
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .q_nib_done(q_nib_done), .s_nib_ready(s_nib_ready), .irq(irq),
  .status(status), .en(en)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wd = 8'h00;
  logic rd = 1'b0, wr = 1'b0;
  logic [2:0] ast = 3'd0;
  logic ihi = 1'b0, ilo = 1'b0, fse = 1'b0, qn = 1'b0, sn = 1'b0;
  logic [7:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  string tag = "R2";
  bit done = 1'b0;

  logic [4:0] m_smp, m_prv;
  logic m_fsmp, m_fprv, m_sv, m_pv, m_irq;
  logic [3:0] m_stat, m_en;

  always #4 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wd), .bus_rdata(rdata), .act_state(ast), .info_hi(ihi),
    .info_lo(ilo), .fsync_err(fse), .q_nib_done(qn), .s_nib_ready(sn),
    .irq(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h16) return {4'h0, m_stat};
    if (a == 8'h17) return {4'h0, m_en};
    return 8'h00;
  endfunction

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_smp = '0; m_prv = '0; m_fsmp = 0; m_fprv = 0; m_sv = 0; m_pv = 0;
    m_irq = 0; m_stat = '0; m_en = '0;
  endtask

  task automatic tick();
    logic [3:0] ev;
    #1;
    chk({tag, " rdata"}, rdata, exp_rd(addr));
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
    @(posedge clk);
    ev = {m_pv && (m_smp != m_prv), m_pv && m_fsmp && !m_fprv, qn, sn};
    m_irq = |(m_stat & m_en);
    m_stat = ((rd && addr == 8'h16) ? 4'h0 : m_stat) | ev;
    if (wr && addr == 8'h17) m_en = wd[3:0];
    m_prv = m_smp; m_fprv = m_fsmp; m_pv = m_sv;
    m_smp = {ihi, ilo, ast}; m_fsmp = fse; m_sv = 1'b1;
    @(negedge clk);
    rd = 0; wr = 0; qn = 0; sn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic read_stat(input logic [3:0] exp, input string t);
    addr = 8'h16; rd = 1; #1;
    chk(t, rdata, {4'h0, exp});
    tick();
  endtask

  initial begin
    fork
      begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    model_reset();
    ast = 3'd5; fse = 1; ihi = 1;
    addr = 8'h16;
    #20;
    chk("R2 status at reset", rdata, 8'h00);
    chk("R2 irq at reset", {7'd0, irq}, 8'h00);
    addr = 8'h17; #1;
    chk("R2 enable at reset", rdata, 8'h00);
    @(negedge clk); rst_n = 1;
    tag = "R11"; addr = 8'h16;
    idle(4);
    chk("R11 held levels ignored", rdata, 8'h00);

    tag = "R8"; addr = 8'h17; wr = 1; wd = 8'hFF; tick();
    chk("R8 enable readback", rdata, 8'h0F);
    addr = 8'h33; tick();
    chk("R1 other address", rdata, 8'h00);

    tag = "R10"; addr = 8'h16; wr = 1; wd = 8'hFF; tick();
    chk("R10 status write ignored", rdata, 8'h00);

    tag = "R7"; qn = 1; tick();
    chk("R7 q bit", rdata, 8'h02);
    idle(1);
    chk("R9 irq raised", {7'd0, irq}, 8'h01);
    tag = "R3"; read_stat(4'h2, "R3 read returns old");
    chk("R3 cleared", rdata, 8'h00);
    tick();
    chk("R9 irq dropped", {7'd0, irq}, 8'h00);

    tag = "R6"; fse = 0; idle(3); fse = 1; idle(2);
    chk("R6 rising edge sets", rdata, 8'h04);
    read_stat(4'h4, "R6 read");
    idle(5);
    chk("R6 held level no reset", rdata, 8'h00);
    fse = 0; idle(2); fse = 1; idle(2);
    chk("R6 second rise sets", rdata, 8'h04);
    read_stat(4'h4, "R6 clear");

    tag = "R5"; ilo = 1; idle(2);
    chk("R5 info change", rdata, 8'h08);
    read_stat(4'h8, "R5 clear");
    ast = 3'd2; idle(2);
    chk("R5 state change", rdata, 8'h08);
    read_stat(4'h8, "R5 clear2");

    tag = "R4"; sn = 1; read_stat(4'h0, "R4 read with pulse");
    chk("R4 event kept", rdata, 8'h01);
    ihi = 0; tick();
    read_stat(4'h1, "R4 read with change");
    chk("R4 change kept", rdata, 8'h08);
    read_stat(4'h8, "R4 clear");

    tag = "R1 R3 R5 R6 R7 R8 R9 R10";
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      addr = (r < 7) ? 8'h16 : (r < 13) ? 8'h17 : 8'($urandom);
      rd = ($urandom % 4) == 0;
      wr = ($urandom % 8) == 0;
      wd = 8'($urandom);
      qn = ($urandom % 10) == 0;
      sn = ($urandom % 10) == 0;
      if ($urandom % 12 == 0) ast = 3'($urandom);
      if ($urandom % 20 == 0) ihi = ~ihi;
      if ($urandom % 20 == 0) ilo = ~ilo;
      if ($urandom % 7 == 0) fse = ~fse;
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule